// File: doc/BRIEF.md
# Three-wire serial EEPROM slave (64 x 16)

This block models a small serial EEPROM as seen from a host on a three-wire bus. The host selects the device, clocks in a start bit, a two-bit opcode and a six-bit word address, and then sends a 16-bit data word if the command needs one. Read commands shift the addressed word back out on the data-out pin. Write, erase, write-all and erase-all start a self-timed programming cycle when chip select drops. Enable and disable commands change a write-protection latch.

The bus pins are brought into the block's clock domain through a short synchronizer, and every serial event is handled on a detected edge. The storage is a register array that reads as all ones after reset. The self-timed cycle is a counter that runs for `PROG_CYCLES` system clocks. While it runs, the serial clock may stay idle. The host reselects the device and watches data out: it reads 0 while the cycle is busy and 1 once the cycle is done. The data-out driver is modelled as a value plus an output enable. The enable is gated directly by chip select.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, the self-timed cycle is idle, `so_oe` is 0 and every word reads 16'hFFFF.
- R2: While the write-enable latch is clear, write, erase, write-all and erase-all frames leave the array unchanged.
- R3: Opcode 00 with address bits [5:4]=11 sets the enable latch, and opcode 00 with [5:4]=00 clears it. Once set, the latch stays set across any number of write-class commands until it is cleared or the block is reset.
- R4: Read is start bit 1, opcode 10, then six address bits MSB first. On the serial clock rise that samples the last address bit, data out shows a dummy 0. Each later rise shows the next data bit, MSB first, for 16 rises. Read works whether the latch is set or clear.
- R5: Write is start bit 1, opcode 01, six address bits, then 16 data bits, all MSB first. When the self-timed cycle ends, the addressed word holds the data.
- R6: The self-timed cycle starts when chip select falls. It stays busy for PROG_CYCLES system clocks and needs no serial clock activity.
- R7: After a launch, whenever chip select is high and no new start bit has been taken, `so_oe` is 1 and `so_data` is 0 while busy and 1 once idle.
- R8: Erase is start bit 1, opcode 11, six address bits. It sets the addressed word to 16'hFFFF and leaves other words untouched.
- R9: Opcode 00 with [5:4]=10 sets every word to 16'hFFFF. Opcode 00 with [5:4]=01, followed by 16 data bits, loads that data into every word, with no erase needed first.
- R10: A write-class frame launches only if chip select falls after its last bit and before the next serial clock rise. A rise at that point, including one seen in the same sampled cycle as the chip-select fall, aborts the frame and leaves the array unchanged.
- R11: `so_oe` is 0 whenever chip select is low, and also when chip select is high with no read or status output in progress.
- R12: A start bit received while the self-timed cycle is busy causes the whole frame to be ignored. The array is unchanged after that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus and run the timer |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for serial data out (0 = high impedance) |

## Verification
Two events can land in the same sampled cycle: the chip-select fall that should launch programming, and a serial clock rise that should abort it. The bench provokes this by raising the serial clock and dropping chip select in the same time step after the last data bit. It then reads the word back and requires it to be unchanged. A second overlap is a new start bit arriving while the timer is still running. The bench sends a full enabled write straight after a launch and checks that the target word keeps its old value. It also checks that the launched write still lands.

// File: rtl/mw_pkg.sv
// Package: shared types for the serial EEPROM model.
// Holds the command-decoder state type, the kind of self-timed operation
// and the two-bit opcode values seen after the start bit.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_PEND,
        ST_READ,
        ST_SKIP
    } mw_state_t;

    typedef enum logic [1:0] {
        K_WRITE,
        K_ERASE,
        K_WRAL,
        K_ERAL
    } mw_kind_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_DIS  = 2'b00;
    localparam logic [1:0] SUB_WRAL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_EN   = 2'b11;

endpackage

// File: rtl/mw_sync.sv
// Module: mw_sync
// Brings the three bus pins into the clk domain through STAGES flops and
// derives the serial clock rising edge and the chip-select falling edge.
// Assumes the bus runs far slower than clk, so each pin level lasts for
// several clk periods.
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_lvl,
    output logic di_lvl,
    output logic sk_rise,
    output logic cs_fall
);

    logic [STAGES:0]   cs_p;
    logic [STAGES:0]   sk_p;
    logic [STAGES-1:0] di_p;

    // Shift the pins through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p <= '0;
            sk_p <= '0;
            di_p <= '0;
        end else begin
            cs_p <= {cs_p[STAGES-1:0], cs};
            sk_p <= {sk_p[STAGES-1:0], sk};
            di_p <= {di_p[STAGES-2:0], di};
        end
    end

    assign cs_lvl  = cs_p[STAGES-1];
    assign di_lvl  = di_p[STAGES-1];
    assign sk_rise = sk_p[STAGES-1] & ~sk_p[STAGES];
    assign cs_fall = cs_p[STAGES] & ~cs_p[STAGES-1];

endmodule

// File: rtl/mw_array.sv
// Module: mw_array
// Register storage of WORDS x DW bits plus the self-timed programming
// timer. A launch pulse latches the operation and holds busy high for
// PROG_CYCLES clocks. The array changes only in the last busy cycle.
// Assumes launch is never issued while busy (the decoder guarantees it).
module mw_array
    import mw_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 2000,
    localparam int AW = $clog2(WORDS),
    localparam int TW = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  mw_kind_t      kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          busy_o
);

    logic [DW-1:0] mem [WORDS];
    logic          busy_q;
    logic [TW-1:0] tmr_q;
    mw_kind_t      kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Run the timer and commit the operation in its final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
            kind_q <= K_WRITE;
            addr_q <= '0;
            data_q <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (busy_q) begin
            if (tmr_q == '0) begin
                busy_q <= 1'b0;
                case (kind_q)
                    K_WRITE: mem[addr_q] <= data_q;
                    K_ERASE: mem[addr_q] <= '1;
                    K_WRAL:  for (int i = 0; i < WORDS; i++) mem[i] <= data_q;
                    K_ERAL:  for (int i = 0; i < WORDS; i++) mem[i] <= '1;
                    default: ;
                endcase
            end else begin
                tmr_q <= tmr_q - 1'b1;
            end
        end else if (launch_i) begin
            busy_q <= 1'b1;
            tmr_q  <= TW'(PROG_CYCLES - 1);
            kind_q <= kind_i;
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign busy_o    = busy_q;

    // R12: the decoder must never launch while a cycle runs.
    a_r12_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !busy_q);

    // R6: a launch makes the block busy in the next cycle.
    a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> busy_q);

    // R6: the cycle ends when the timer runs out.
    a_r6_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && tmr_q == '0) |=> !busy_q);

    // R5: storage only changes in the final cycle of a busy period.
    a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && tmr_q == '0) |=> $stable(mem[0]));

endmodule

// File: rtl/mw_cmd.sv
// Module: mw_cmd
// Serial command decoder. It takes the start bit, the opcode, the address
// and the data on sampled serial clock rises. It keeps the write-enable
// latch, drives read data and busy status, and issues a launch pulse when
// chip select falls inside the window after a write-class frame.
// Assumes inputs come from mw_sync and that AW >= 2.
module mw_cmd
    import mw_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    localparam int AW = $clog2(WORDS),
    localparam int CW = $clog2(((DW > AW) ? DW : AW) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          di_lvl,
    input  logic          sk_rise,
    input  logic          cs_fall,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          launch_o,
    output mw_kind_t      kind_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          out_en_o,
    output logic          out_bit_o
);

    mw_state_t     st_q;
    logic [1:0]    op_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] shr_q;
    mw_kind_t      kind_q;
    logic          wen_q;
    logic          stat_q;
    logic          launch_q;
    logic [AW-1:0] addr_nxt;
    logic [1:0]    sub_nxt;

    assign addr_nxt  = {addr_q[AW-2:0], di_lvl};
    assign sub_nxt   = addr_nxt[AW-1:AW-2];
    assign rd_addr_o = addr_nxt;

    // Frame decoder, enable latch, status flag and launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            op_q     <= '0;
            cnt_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            shr_q    <= '0;
            kind_q   <= K_WRITE;
            wen_q    <= 1'b0;
            stat_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            if (!cs_lvl) begin
                if (cs_fall && st_q == ST_PEND && !sk_rise && !busy_i && wen_q) begin
                    launch_q <= 1'b1;
                    stat_q   <= 1'b1;
                end
                st_q <= ST_IDLE;
            end else if (sk_rise) begin
                case (st_q)
                    ST_IDLE: begin
                        if (di_lvl) begin
                            if (busy_i) begin
                                st_q <= ST_SKIP;
                            end else begin
                                st_q   <= ST_OPC;
                                cnt_q  <= '0;
                                stat_q <= 1'b0;
                            end
                        end
                    end
                    ST_OPC: begin
                        op_q  <= {op_q[0], di_lvl};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(1)) begin
                            st_q  <= ST_ADDR;
                            cnt_q <= '0;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= addr_nxt;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CW'(AW - 1)) begin
                            cnt_q <= '0;
                            case (op_q)
                                OP_READ: begin
                                    st_q  <= ST_READ;
                                    shr_q <= rd_data_i;
                                end
                                OP_WRITE: begin
                                    st_q   <= ST_DATA;
                                    kind_q <= K_WRITE;
                                end
                                OP_ERASE: begin
                                    st_q   <= ST_PEND;
                                    kind_q <= K_ERASE;
                                end
                                default: begin
                                    case (sub_nxt)
                                        SUB_EN:   begin wen_q <= 1'b1; st_q <= ST_SKIP; end
                                        SUB_DIS:  begin wen_q <= 1'b0; st_q <= ST_SKIP; end
                                        SUB_ERAL: begin kind_q <= K_ERAL; st_q <= ST_PEND; end
                                        default:  begin kind_q <= K_WRAL; st_q <= ST_DATA; end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        data_q <= {data_q[DW-2:0], di_lvl};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CW'(DW - 1)) st_q <= ST_PEND;
                    end
                    ST_PEND: st_q <= ST_SKIP;
                    ST_READ: begin
                        if (cnt_q == '0) begin
                            cnt_q <= CW'(1);
                        end else if (cnt_q == CW'(DW)) begin
                            st_q <= ST_SKIP;
                        end else begin
                            shr_q <= {shr_q[DW-2:0], 1'b0};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pick what the data-out pin shows: read bits or busy status.
    always_comb begin
        out_en_o  = 1'b0;
        out_bit_o = 1'b0;
        if (st_q == ST_READ) begin
            out_en_o  = 1'b1;
            out_bit_o = (cnt_q == '0) ? 1'b0 : shr_q[DW-1];
        end else if (stat_q && (st_q == ST_IDLE || st_q == ST_SKIP)) begin
            out_en_o  = 1'b1;
            out_bit_o = !busy_i;
        end
    end

    assign launch_o = launch_q;
    assign kind_o   = kind_q;
    assign addr_o   = addr_q;
    assign data_o   = data_q;

    // R3: the enable latch only drops after an address-phase decision.
    a_r3_wen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wen_q |=> (wen_q || $past(st_q) == ST_ADDR));

    // R2: a launch never follows a frame while the latch is clear.
    a_r2_launch_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        launch_q |-> $past(wen_q));

    // R4: the read bit counter never runs past the word.
    a_r4_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ) |-> (cnt_q <= CW'(DW)));

endmodule

// File: rtl/mw_eeprom.sv
// Module: mw_eeprom (top)
// Serial EEPROM slave: synchronizer, command decoder and storage with a
// self-timed programming timer. Data out is a value plus an enable that
// is gated by the raw chip-select pin, so the output goes high impedance
// as soon as the host deselects.
// Assumes clk is many times faster than the serial clock.
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic so_data,
    output logic so_oe
);

    localparam int AW = $clog2(WORDS);

    logic          cs_lvl, di_lvl, sk_rise, cs_fall;
    logic          busy, launch, out_en, out_bit;
    mw_kind_t      kind;
    logic [AW-1:0] op_addr, rd_addr;
    logic [DW-1:0] op_data, rd_data;

    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_lvl(cs_lvl), .di_lvl(di_lvl), .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_cmd #(.WORDS(WORDS), .DW(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .di_lvl(di_lvl),
        .sk_rise(sk_rise), .cs_fall(cs_fall), .busy_i(busy),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr), .launch_o(launch),
        .kind_o(kind), .addr_o(op_addr), .data_o(op_data),
        .out_en_o(out_en), .out_bit_o(out_bit)
    );

    mw_array #(.WORDS(WORDS), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_array (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .kind_i(kind),
        .addr_i(op_addr), .data_i(op_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .busy_o(busy)
    );

    assign so_oe   = cs & out_en;
    assign so_data = out_bit;

endmodule

// File: tb/sim_mw_eeprom.sv
// Directed bench for mw_eeprom: one task per scenario, each checking itself.
module sim_mw_eeprom;

    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic so_data, so_oe;
    int   total = 0, bad = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    mw_eeprom #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .so_data(so_data), .so_oe(so_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di = b; tick(8);
        sk = 1'b1; tick(8);
        sk = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic begin_frame(input logic [1:0] op, input logic [5:0] a);
        cs = 1'b0; tick(6);
        cs = 1'b1; tick(4);
        send_bit(1'b1);
        send_bits({14'd0, op}, 2);
        send_bits({10'd0, a}, 6);
    endtask

    // Normal deselect inside the window.
    task automatic drop_cs;
        tick(2); cs = 1'b0; tick(6);
    endtask

    // Reselect and poll status until ready; checks busy then ready and length.
    task automatic poll_ready(input string tag);
        int n = 8;
        cs = 1'b1; tick(2); n += 2;
        chk({tag, " status oe"}, {15'd0, so_oe}, 16'd1);
        chk({tag, " status busy"}, {15'd0, so_data}, 16'd0);
        while (so_data !== 1'b1 && n < 4 * PROG) begin tick(1); n++; end
        total++;
        if (n < PROG || n > PROG + 10) begin
            bad++;
            $display("FAIL R6 busy length actual=%0d expected=%0d..%0d", n, PROG, PROG + 10);
        end
        cs = 1'b0; tick(4);
    endtask

    task automatic do_read(input logic [5:0] a, output logic [15:0] v);
        begin_frame(2'b10, a);
        tick(2);
        chk("R4 dummy bit", {15'd0, so_data}, 16'd0);
        chk("R4 read oe", {15'd0, so_oe}, 16'd1);
        for (int i = 15; i >= 0; i--) begin
            send_bit(1'b0); tick(2);
            v[i] = so_data;
        end
        cs = 1'b0; tick(2);
        chk("R11 oe after deselect", {15'd0, so_oe}, 16'd0);
        tick(4);
    endtask

    task automatic expect_word(input string tag, input logic [5:0] a, input logic [15:0] exp);
        logic [15:0] v;
        do_read(a, v);
        chk(tag, v, exp);
    endtask

    task automatic do_ctl(input logic [5:0] a);
        begin_frame(2'b00, a);
        cs = 1'b0; tick(6);
    endtask

    task automatic t_reset;
        chk("R1 oe at reset", {15'd0, so_oe}, 16'd0);
        cs = 1'b1; tick(4);
        chk("R11 idle oe", {15'd0, so_oe}, 16'd0);
        cs = 1'b0; tick(4);
        expect_word("R1 word after reset", 6'd5, 16'hFFFF);
    endtask

    task automatic t_locked_write;
        begin_frame(2'b01, 6'd5); send_bits(16'h1234, 16); drop_cs; tick(PROG + 20);
        expect_word("R2 write while locked", 6'd5, 16'hFFFF);
        begin_frame(2'b00, 6'b100000); drop_cs; tick(PROG + 20);
        expect_word("R2 erase-all while locked", 6'd0, 16'hFFFF);
    endtask

    task automatic t_write;
        do_ctl(6'b110000);
        begin_frame(2'b01, 6'd5); send_bits(16'hA5C3, 16); drop_cs; poll_ready("R7 write");
        expect_word("R5 written word", 6'd5, 16'hA5C3);
        begin_frame(2'b01, 6'd6); send_bits(16'h0F0F, 16); drop_cs; poll_ready("R7 second");
        expect_word("R3 latch still set", 6'd6, 16'h0F0F);
    endtask

    task automatic t_erase;
        begin_frame(2'b11, 6'd5); drop_cs; poll_ready("R7 erase");
        expect_word("R8 erased word", 6'd5, 16'hFFFF);
        expect_word("R8 neighbour kept", 6'd6, 16'h0F0F);
    endtask

    task automatic t_window;
        begin_frame(2'b01, 6'd7); send_bits(16'h1111, 16);
        send_bit(1'b0); cs = 1'b0; tick(PROG + 20);
        expect_word("R10 late deselect", 6'd7, 16'hFFFF);
        begin_frame(2'b01, 6'd8); send_bits(16'h2222, 16);
        tick(2); sk = 1'b1; cs = 1'b0; tick(8); sk = 1'b0; tick(PROG + 20);
        expect_word("R10 same-cycle rise", 6'd8, 16'hFFFF);
    endtask

    task automatic t_busy_ignore;
        begin_frame(2'b01, 6'd9); send_bits(16'hBEEF, 16); drop_cs;
        cs = 1'b1; tick(2);
        chk("R7 busy on reselect", {15'd0, so_data}, 16'd0);
        send_bit(1'b1); send_bits(16'h0001, 2); send_bits(16'd10, 6);
        send_bits(16'hCAFE, 16); drop_cs; tick(PROG + 20);
        expect_word("R12 ignored while busy", 6'd10, 16'hFFFF);
        expect_word("R12 first write landed", 6'd9, 16'hBEEF);
    endtask

    task automatic t_all;
        begin_frame(2'b00, 6'b010000); send_bits(16'h3C3C, 16); drop_cs; poll_ready("R7 wral");
        expect_word("R9 write-all low", 6'd0, 16'h3C3C);
        expect_word("R9 write-all high", 6'd63, 16'h3C3C);
        do_ctl(6'b100000); cs = 1'b1; tick(2); cs = 1'b0; tick(PROG + 20);
        expect_word("R9 erase-all", 6'd40, 16'hFFFF);
    endtask

    task automatic t_disable;
        do_ctl(6'b000000);
        begin_frame(2'b01, 6'd2); send_bits(16'h0001, 16); drop_cs; tick(PROG + 20);
        expect_word("R3 write after disable", 6'd2, 16'hFFFF);
        do_ctl(6'b110000);
        begin_frame(2'b01, 6'd2); send_bits(16'h8001, 16); drop_cs; poll_ready("R7 reenable");
        do_ctl(6'b000000);
        expect_word("R4 read while locked", 6'd2, 16'h8001);
    endtask

    initial begin
        tick(5); rst_n = 1'b1; tick(3);
        t_reset;
        t_locked_write;
        t_write;
        t_erase;
        t_window;
        t_busy_ignore;
        t_all;
        t_disable;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule